// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Data Port

This block gives a host processor a narrow window onto a 128 KiB work RAM. Instead of decoding the whole RAM into the host's register space, the host loads a 17-bit pointer through three byte-wide pointer registers. It then moves bytes one at a time through a single data register. Every read or write of the data register transfers one byte at the current pointer and then advances the pointer by one. A block copy therefore needs one pointer setup followed by a stream of data accesses.

The register side is a simple strobe bus with a 2-bit register select. Register select encoding: 0 selects the data register, 1 the pointer low byte, 2 the pointer middle byte and 3 the pointer high register. The RAM side is a synchronous single-port RAM with a one-cycle read latency. The RAM address is the pointer placed in a fixed bank at base 0x7E0000 of a 24-bit space.

A small response state machine has three states:
- ST_IDLE: no response pending.
- ST_RD_RAM: RAM read data is returned.
- ST_RD_OPEN: the captured open-bus byte is returned.

The machine has three transitions:
- Any state goes to ST_RD_RAM on a data-register read.
- Any state goes to ST_RD_OPEN on a read of a pointer register.
- Any state goes to ST_IDLE when no read strobe is present.

Top module: `wram_port`

## Requirements
- R1: After reset the pointer is zero (`ram_addr` = 0x7E0000), and `reg_ready` and `ram_we` are low.
- R2: A write to select 1 sets pointer bits 7:0, and a write to select 2 sets pointer bits 15:8; the other pointer bits are unchanged.
- R3: A write to select 3 sets only pointer bit 16, taken from data bit 0; data bits 7:1 and pointer bits 15:0 are unaffected.
- R4: A read of select 0 returns the RAM byte at the current pointer, with `reg_ready` high in the cycle after the strobe, and the pointer then increments by one.
- R5: A write to select 0 drives `ram_we` high in the strobe cycle with `ram_wdata` equal to the written byte at the current pointer, and the pointer then increments by one.
- R6: `ram_addr` always equals 0x7E0000 plus the 17-bit pointer.
- R7: Incrementing from pointer 0x1FFFF wraps the pointer to 0x00000.
- R8: A read of select 1, 2 or 3 returns the `open_bus` value sampled in the strobe cycle, with `reg_ready` high in the next cycle; the pointer is unchanged.
- R9: If `reg_rd` and `reg_wr` are high together, the access is handled as a read only: `ram_we` stays low and the pointer advances once.
- R10: Data-register reads may be issued on consecutive cycles, each returning the next sequential byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select (0 data, 1 pointer low, 2 pointer middle, 3 pointer high) |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| open_bus | input | 8 | Value returned for reads of the pointer registers |
| reg_rdata | output | 8 | Read data, valid while `reg_ready` is high |
| reg_ready | output | 1 | Read data valid, one cycle after a read strobe |
| ram_addr | output | 24 | RAM byte address (bank base plus pointer) |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |

## Verification
The hardest case to reach from the ports is the pointer wrap. Reaching it by streaming data accesses would take 128K of them. The stimulus instead loads the pointer to 0x1FFFE through the three pointer registers and then writes and reads across the 0x1FFFF boundary. The two other awkward cases are a read strobe coinciding with a write strobe and unbroken back-to-back reads. Both are driven directly, while a scoreboard queue matches each returned byte against a shadow of the bench RAM.

// File: rtl/wram_pkg.sv
package wram_pkg;

    typedef enum logic [1:0] {
        SEL_DATA    = 2'd0,
        SEL_PTR_LO  = 2'd1,
        SEL_PTR_MID = 2'd2,
        SEL_PTR_HI  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RAM  = 2'd1,
        ST_RD_OPEN = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/wram_ptr.sv
module wram_ptr #(
    parameter int PTR_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_mid,
    input  logic             ld_hi,
    input  logic             inc,
    input  logic [7:0]       wdata,
    output logic [PTR_W-1:0] ptr
);
    localparam int HI_W = PTR_W - 16;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (inc) begin
            ptr <= ptr + PTR_W'(1);
        end else begin
            if (ld_lo)  ptr[7:0]  <= wdata;
            if (ld_mid) ptr[15:8] <= wdata;
            if (ld_hi)  ptr[PTR_W-1:16] <= wdata[HI_W-1:0];
        end
    end

    // R7
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&ptr)) |=> (ptr == '0));

    // R3
    hi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !inc) |=> (ptr[15:0] == $past(ptr[15:0])));

    // R2
    lo_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !ld_mid && !ld_hi && !inc) |=> (ptr[PTR_W-1:8] == $past(ptr[PTR_W-1:8])));

endmodule

// File: rtl/wram_seq.sv
module wram_seq
    import wram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       rd,
    input  logic       wr,
    output rsp_state_e state,
    output logic       inc,
    output logic       ld_lo,
    output logic       ld_mid,
    output logic       ld_hi,
    output logic       ram_we
);
    rsp_state_e state_nx;
    reg_sel_e   sel_e;
    logic       wr_only;

    assign sel_e   = reg_sel_e'(sel);
    assign wr_only = wr && !rd;

    always_comb begin
        if (!rd)                   state_nx = ST_IDLE;
        else if (sel_e == SEL_DATA) state_nx = ST_RD_RAM;
        else                       state_nx = ST_RD_OPEN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        inc    = 1'b0;
        ld_lo  = 1'b0;
        ld_mid = 1'b0;
        ld_hi  = 1'b0;
        ram_we = 1'b0;
        unique case (sel_e)
            SEL_DATA: begin
                inc    = rd || wr;
                ram_we = wr_only;
            end
            SEL_PTR_LO:  ld_lo  = wr_only;
            SEL_PTR_MID: ld_mid = wr_only;
            SEL_PTR_HI:  ld_hi  = wr_only;
            default: ;
        endcase
    end

    // R4
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> $past(rd));

    // R9
    no_write_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> !ram_we);

endmodule

// File: rtl/wram_port.sv
module wram_port
    import wram_pkg::*;
#(
    parameter int              PTR_W     = 17,
    parameter int              ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] BANK_BASE = 24'h7E0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        open_bus,
    output logic [7:0]        reg_rdata,
    output logic              reg_ready,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_we,
    input  logic [7:0]        ram_rdata
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1) << PTR_W;

    rsp_state_e       state;
    logic             inc, ld_lo, ld_mid, ld_hi;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       ob_q;

    wram_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (reg_sel),
        .rd     (reg_rd),
        .wr     (reg_wr),
        .state  (state),
        .inc    (inc),
        .ld_lo  (ld_lo),
        .ld_mid (ld_mid),
        .ld_hi  (ld_hi),
        .ram_we (ram_we)
    );

    wram_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_lo  (ld_lo),
        .ld_mid (ld_mid),
        .ld_hi  (ld_hi),
        .inc    (inc),
        .wdata  (reg_wdata),
        .ptr    (ptr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      ob_q <= '0;
        else if (reg_rd) ob_q <= open_bus;
    end

    assign ram_addr  = BANK_BASE + ADDR_W'(ptr);
    assign ram_wdata = reg_wdata;

    always_comb begin
        reg_ready = 1'b0;
        reg_rdata = '0;
        unique case (state)
            ST_RD_RAM: begin
                reg_ready = 1'b1;
                reg_rdata = ram_rdata;
            end
            ST_RD_OPEN: begin
                reg_ready = 1'b1;
                reg_rdata = ob_q;
            end
            default: ;
        endcase
    end

    // R6
    addr_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_addr - BANK_BASE) < SPAN);

    // R5
    write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ((ram_addr - BANK_BASE) == (($past(ram_addr) - BANK_BASE + 1) % SPAN)));

    // R8
    open_read_holds_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel != 2'd0) |=> $stable(ram_addr));

endmodule

// File: tb/wram_port_tb_top.sv
module wram_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  open_bus = '0;
    logic [7:0]  reg_rdata;
    logic        reg_ready;
    logic [23:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  ram_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] ram_mem [int];
    logic [7:0] shadow  [int];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    int         mptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wram_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .open_bus(open_bus),
        .reg_rdata(reg_rdata), .reg_ready(reg_ready), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
        ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] peek(input int p);
        return shadow.exists(p) ? shadow[p] : 8'h00;
    endfunction

    // monitor: pops expected read data when the port answers
    always @(negedge clk) begin
        if (rst_n && reg_ready) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected ready", 1, 0);
            end else begin
                chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        #1;
        if (s == 2'd0) begin
            chk("R5 we", ram_we, 1);
            chk("R5 wdata", ram_wdata, d);
            chk("R6 addr", ram_addr, 24'h7E0000 + mptr);
            shadow[mptr] = d;
            mptr = (mptr + 1) % 131072;
        end else begin
            chk("R2 no we", ram_we, 0);
            if (s == 2'd1) mptr = (mptr & 32'h1FF00) | d;
            if (s == 2'd2) mptr = (mptr & 32'h100FF) | (int'(d) << 8);
            if (s == 2'd3) mptr = (mptr & 32'h0FFFF) | (int'(d[0]) << 16);
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_push(input logic [1:0] s, input string tag);
        reg_sel = s; reg_rd = 1'b1;
        if (s == 2'd0) begin
            exp_q.push_back(peek(mptr));
            mptr = (mptr + 1) % 131072;
        end else begin
            exp_q.push_back(open_bus);
        end
        tag_q.push_back(tag);
    endtask

    task automatic rd_burst(input logic [1:0] s, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_push(s, tag);
        end
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_ptr(input string tag);
        @(negedge clk);
        chk(tag, ram_addr, 24'h7E0000 + mptr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk("R1 addr", ram_addr, 24'h7E0000);
        chk("R1 ready", reg_ready, 0);
        chk("R1 we", ram_we, 0);

        // R2 and R3: pointer assembly
        wr_reg(2'd1, 8'h34);
        wr_reg(2'd2, 8'h12);
        chk_ptr("R2 lo/mid");
        wr_reg(2'd3, 8'hFE);
        chk_ptr("R3 bit0 clear");
        chk("R3 addr value", ram_addr, 24'h7E1234);
        wr_reg(2'd3, 8'h01);
        chk("R3 bit16 set", ram_addr, 24'h7F1234);
        wr_reg(2'd3, 8'hFF);
        chk("R3 upper bits ignored", ram_addr, 24'h7F1234);

        // R5: sequential writes
        wr_reg(2'd0, 8'hA0);
        wr_reg(2'd0, 8'hA1);
        wr_reg(2'd0, 8'hA2);
        wr_reg(2'd0, 8'hA3);
        chk_ptr("R5 ptr advanced");

        // R10 and R4: back-to-back reads
        wr_reg(2'd1, 8'h34);
        rd_burst(2'd0, 4, "R10 burst read");
        chk_ptr("R4 ptr after reads");
        rd_burst(2'd0, 1, "R4 single read");

        // R8: open-bus read of pointer registers
        open_bus = 8'h5A;
        rd_burst(2'd1, 1, "R8 lo open bus");
        open_bus = 8'hC3;
        rd_burst(2'd3, 1, "R8 hi open bus");
        chk_ptr("R8 ptr unchanged");

        // R7: wrap at the top of the bank
        wr_reg(2'd1, 8'hFE);
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd3, 8'h01);
        chk("R7 at 1FFFE", ram_addr, 24'h7FFFFE);
        wr_reg(2'd0, 8'h77);
        wr_reg(2'd0, 8'h88);
        chk("R7 wrapped", ram_addr, 24'h7E0000);
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd3, 8'h01);
        rd_burst(2'd0, 2, "R7 read across wrap");
        chk("R7 addr after read", ram_addr, 24'h7E0001);

        // R9: simultaneous read and write strobes
        wr_reg(2'd1, 8'h10);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd0, 8'h3C);
        wr_reg(2'd1, 8'h10);
        @(negedge clk);
        reg_wdata = 8'hEE;
        reg_wr = 1'b1;
        rd_push(2'd0, "R9 read wins");
        #1;
        chk("R9 no we", ram_we, 0);
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        chk_ptr("R9 single increment");
        wr_reg(2'd1, 8'h10);
        rd_burst(2'd0, 1, "R9 byte kept");

        repeat (3) @(negedge clk);
        chk("R4 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule